// File: doc/BRIEF.md
# Pointer-Register Address Generator

This block works out the data-memory address for every indirect load or store that goes through one of three 16-bit pointers (X, Y, Z). Each pointer is a pair of 8-bit registers. For each request it also works out the new pointer value and whether that value must be written back. It handles five access styles:

- plain indirect
- post-increment
- pre-decrement
- pointer plus an unsigned displacement
- a direct address carried in the instruction

It also forms program-memory byte addresses, which may only come from Z, with or without a post-increment.

The register file holds the pointer values and feeds them in. The block returns the effective address one clock later, together with a program-memory tag. The write-back is returned as a low byte and a high byte under a single enable, so the register file updates both halves of the pair in the same cycle. An illegal request, such as a displacement on X, produces no address and no write-back, and raises a flag instead.

Top module: `adrgen_top`

## Requirements
- R1: Results appear on the outputs one clock after a request is sampled with `req_i`=1. A cycle with `req_i`=0 gives `vld_o`=0, `illegal_o`=0, `wb_en_o`=0, `pm_o`=0, and all address and write-back buses at 0.
- R2: Pointer selection uses `sel_i`: 0 picks X, 1 picks Y, 2 picks Z. In plain mode (`mode_i`=0), `addr_o` is the selected pointer and `wb_en_o`=0.
- R3: In post-increment mode (`mode_i`=1), `addr_o` is the old pointer value. `wb_en_o`=1, and {`wb_hi_o`,`wb_lo_o`} is the old value plus one.
- R4: In pre-decrement mode (`mode_i`=2), both `addr_o` and {`wb_hi_o`,`wb_lo_o`} equal the pointer minus one, with `wb_en_o`=1.
- R5: In displacement mode (`mode_i`=3) on Y or Z, `addr_o` is the pointer plus the zero-extended 6-bit `disp_i`, and `wb_en_o`=0.
- R6: Displacement mode on X gives `illegal_o`=1, `vld_o`=0 and `wb_en_o`=0.
- R7: In direct mode (`mode_i`=4), `addr_o` equals `direct_i` for any `sel_i`, and `wb_en_o`=0.
- R8: Program-memory modes are `mode_i`=5 (no update) and `mode_i`=6 (post-increment). On Z they give `pm_o`=1 and `addr_o` equal to Z. Mode 6 also gives `wb_en_o`=1 with the value Z+1.
- R9: Program-memory modes on X or Y are illegal. So are `sel_i`=3 with any pointer mode and `mode_i`=7. When a request is illegal, `illegal_o`=1, `vld_o`=0, `pm_o`=0, `wb_en_o`=0, and `addr_o`=0.
- R10: Pointer arithmetic wraps modulo 2^16: 0xFFFF+1 gives 0x0000, 0x0000-1 gives 0xFFFF, and displacement sums wrap the same way.
- R11: `wb_sel_o` equals `sel_i` of the request whenever `wb_en_o`=1. `vld_o` and `illegal_o` are never both 1.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| sel_i | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| mode_i | input | 3 | Addressing mode code |
| disp_i | input | 6 | Unsigned displacement |
| direct_i | input | 16 | Direct address |
| ptr_x_i | input | 16 | Current X pointer |
| ptr_y_i | input | 16 | Current Y pointer |
| ptr_z_i | input | 16 | Current Z pointer |
| vld_o | output | 1 | Legal result present |
| illegal_o | output | 1 | Illegal request flag |
| pm_o | output | 1 | Address targets program memory |
| addr_o | output | 16 | Effective address |
| wb_en_o | output | 1 | Pointer write-back enable |
| wb_sel_o | output | 2 | Pointer being written back |
| wb_lo_o | output | 8 | Write-back low byte |
| wb_hi_o | output | 8 | Write-back high byte |

## Verification
The only state is the single output register stage. If the next-value logic picks the wrong pointer, applies the wrong offset, or lets an enable through when it should not, the error shows at the ports in the cycle right after the request. There it is seen as a wrong address, a wrong write-back pair, or a write-back enable that should not be there. Carry and borrow errors show only at the 0xFFFF and 0x0000 boundaries, so the stimulus steers pointers there on purpose. Illegal combinations are checked by confirming that no enable and no address leak out alongside the flag.

// File: rtl/adrgen_pkg.sv
package adrgen_pkg;
  typedef enum logic [2:0] {
    MODE_PLAIN   = 3'd0,
    MODE_POSTINC = 3'd1,
    MODE_PREDEC  = 3'd2,
    MODE_DISP    = 3'd3,
    MODE_DIRECT  = 3'd4,
    MODE_PM      = 3'd5,
    MODE_PM_INC  = 3'd6,
    MODE_RSVD    = 3'd7
  } mode_e;

  localparam logic [1:0] SEL_X = 2'd0;
  localparam logic [1:0] SEL_Y = 2'd1;
  localparam logic [1:0] SEL_Z = 2'd2;
  localparam int unsigned NUM_PTR = 3;
endpackage

// File: rtl/adrgen_ptr_mux.sv
module adrgen_ptr_mux #(
  parameter int unsigned PTR_W = 16
) (
  input  logic [1:0]       sel_i,
  input  logic [PTR_W-1:0] ptr_x_i,
  input  logic [PTR_W-1:0] ptr_y_i,
  input  logic [PTR_W-1:0] ptr_z_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             sel_ok_o
);
  import adrgen_pkg::*;

  logic [PTR_W-1:0] ptrs [NUM_PTR];
  logic [NUM_PTR-1:0] hit;

  assign ptrs[0] = ptr_x_i;
  assign ptrs[1] = ptr_y_i;
  assign ptrs[2] = ptr_z_i;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_hit
    assign hit[g] = (sel_i == 2'(g));
  end

  always_comb begin
    ptr_o = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (hit[i]) ptr_o = ptrs[i];
    end
  end

  assign sel_ok_o = |hit;
endmodule

// File: rtl/adrgen_calc.sv
module adrgen_calc #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned DISP_W = 6
) (
  input  adrgen_pkg::mode_e  mode_i,
  input  logic [1:0]         sel_i,
  input  logic               sel_ok_i,
  input  logic [PTR_W-1:0]   ptr_i,
  input  logic [DISP_W-1:0]  disp_i,
  input  logic [PTR_W-1:0]   direct_i,
  output logic [PTR_W-1:0]   addr_o,
  output logic [PTR_W-1:0]   wb_val_o,
  output logic               wb_en_o,
  output logic               pm_o,
  output logic               illegal_o
);
  import adrgen_pkg::*;

  logic [PTR_W-1:0] ptr_inc, ptr_dec, ptr_disp;
  logic [PTR_W-1:0] addr_raw, wb_raw;
  logic             wb_raw_en, pm_raw, bad;

  // all sums truncate to PTR_W, giving modulo wrap
  assign ptr_inc  = ptr_i + PTR_W'(1);
  assign ptr_dec  = ptr_i - PTR_W'(1);
  assign ptr_disp = ptr_i + PTR_W'(disp_i);

  always_comb begin
    addr_raw  = ptr_i;
    wb_raw    = '0;
    wb_raw_en = 1'b0;
    pm_raw    = 1'b0;
    bad       = !sel_ok_i;
    unique case (mode_i)
      MODE_PLAIN: ;
      MODE_POSTINC: begin
        wb_raw    = ptr_inc;
        wb_raw_en = 1'b1;
      end
      MODE_PREDEC: begin
        addr_raw  = ptr_dec;
        wb_raw    = ptr_dec;
        wb_raw_en = 1'b1;
      end
      MODE_DISP: begin
        addr_raw = ptr_disp;
        bad      = !sel_ok_i || (sel_i == SEL_X);
      end
      MODE_DIRECT: begin
        addr_raw = direct_i;
        bad      = 1'b0;
      end
      MODE_PM: begin
        pm_raw = 1'b1;
        bad    = (sel_i != SEL_Z);
      end
      MODE_PM_INC: begin
        pm_raw    = 1'b1;
        wb_raw    = ptr_inc;
        wb_raw_en = 1'b1;
        bad       = (sel_i != SEL_Z);
      end
      default: bad = 1'b1;
    endcase
  end

  assign illegal_o = bad;
  assign addr_o    = bad ? '0 : addr_raw;
  assign wb_val_o  = (bad || !wb_raw_en) ? '0 : wb_raw;
  assign wb_en_o   = !bad && wb_raw_en;
  assign pm_o      = !bad && pm_raw;
endmodule

// File: rtl/adrgen_top.sv
module adrgen_top #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned DISP_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        sel_i,
  input  logic [2:0]        mode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [PTR_W-1:0]  direct_i,
  input  logic [PTR_W-1:0]  ptr_x_i,
  input  logic [PTR_W-1:0]  ptr_y_i,
  input  logic [PTR_W-1:0]  ptr_z_i,
  output logic              vld_o,
  output logic              illegal_o,
  output logic              pm_o,
  output logic [PTR_W-1:0]  addr_o,
  output logic              wb_en_o,
  output logic [1:0]        wb_sel_o,
  output logic [PTR_W/2-1:0] wb_lo_o,
  output logic [PTR_W/2-1:0] wb_hi_o
);
  import adrgen_pkg::*;

  localparam int unsigned BYTE_W = PTR_W / 2;

  logic [PTR_W-1:0] ptr_sel, addr_c, wb_c;
  logic             sel_ok, wb_en_c, pm_c, bad_c;

  adrgen_ptr_mux #(.PTR_W(PTR_W)) u_mux (
    .sel_i    (sel_i),
    .ptr_x_i  (ptr_x_i),
    .ptr_y_i  (ptr_y_i),
    .ptr_z_i  (ptr_z_i),
    .ptr_o    (ptr_sel),
    .sel_ok_o (sel_ok)
  );

  adrgen_calc #(.PTR_W(PTR_W), .DISP_W(DISP_W)) u_calc (
    .mode_i    (mode_e'(mode_i)),
    .sel_i     (sel_i),
    .sel_ok_i  (sel_ok),
    .ptr_i     (ptr_sel),
    .disp_i    (disp_i),
    .direct_i  (direct_i),
    .addr_o    (addr_c),
    .wb_val_o  (wb_c),
    .wb_en_o   (wb_en_c),
    .pm_o      (pm_c),
    .illegal_o (bad_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o     <= 1'b0;
      illegal_o <= 1'b0;
      pm_o      <= 1'b0;
      addr_o    <= '0;
      wb_en_o   <= 1'b0;
      wb_sel_o  <= '0;
      wb_lo_o   <= '0;
      wb_hi_o   <= '0;
    end else if (req_i) begin
      vld_o     <= !bad_c;
      illegal_o <= bad_c;
      pm_o      <= pm_c;
      addr_o    <= addr_c;
      wb_en_o   <= wb_en_c;
      wb_sel_o  <= wb_en_c ? sel_i : 2'd0;
      wb_lo_o   <= wb_c[BYTE_W-1:0];
      wb_hi_o   <= wb_c[PTR_W-1:BYTE_W];
    end else begin
      vld_o     <= 1'b0;
      illegal_o <= 1'b0;
      pm_o      <= 1'b0;
      addr_o    <= '0;
      wb_en_o   <= 1'b0;
      wb_sel_o  <= '0;
      wb_lo_o   <= '0;
      wb_hi_o   <= '0;
    end
  end
endmodule

// File: rtl/adrgen_chk.sv
module adrgen_chk #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned DISP_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [1:0]        sel_i,
  input logic [2:0]        mode_i,
  input logic [PTR_W-1:0]  ptr_z_i,
  input logic              vld_o,
  input logic              illegal_o,
  input logic              pm_o,
  input logic [PTR_W-1:0]  addr_o,
  input logic              wb_en_o,
  input logic [1:0]        wb_sel_o,
  input logic [PTR_W/2-1:0] wb_lo_o,
  input logic [PTR_W/2-1:0] wb_hi_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_excl_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld_o && illegal_o));

  p_x_disp_illegal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(req_i && sel_i == 2'd0 && mode_i == 3'd3) |-> illegal_o && !wb_en_o);

  p_postinc_value_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(req_i && mode_i == 3'd1 && sel_i != 2'd3)
      |-> wb_en_o && ({wb_hi_o, wb_lo_o} == addr_o + PTR_W'(1)));

  p_predec_same_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(req_i && mode_i == 3'd2 && sel_i != 2'd3)
      |-> wb_en_o && ({wb_hi_o, wb_lo_o} == addr_o));

  p_plain_no_wb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(req_i && (mode_i == 3'd0 || mode_i == 3'd3 || mode_i == 3'd4 || mode_i == 3'd5))
      |-> !wb_en_o);

  p_pm_addr_z_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(req_i && sel_i == 2'd2 && mode_i == 3'd5) |-> pm_o && addr_o == $past(ptr_z_i));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(!req_i) |-> !vld_o && !illegal_o && !wb_en_o);

  p_wbsel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && wb_en_o |-> wb_sel_o == $past(sel_i));
endmodule

bind adrgen_top adrgen_chk #(.PTR_W(PTR_W), .DISP_W(DISP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .sel_i     (sel_i),
  .mode_i    (mode_i),
  .ptr_z_i   (ptr_z_i),
  .vld_o     (vld_o),
  .illegal_o (illegal_o),
  .pm_o      (pm_o),
  .addr_o    (addr_o),
  .wb_en_o   (wb_en_o),
  .wb_sel_o  (wb_sel_o),
  .wb_lo_o   (wb_lo_o),
  .wb_hi_o   (wb_hi_o)
);

// File: tb/sim_adrgen_top.sv
module sim_adrgen_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  sel_i = '0;
  logic [2:0]  mode_i = '0;
  logic [5:0]  disp_i = '0;
  logic [15:0] direct_i = '0, ptr_x_i = '0, ptr_y_i = '0, ptr_z_i = '0;
  logic        vld_o, illegal_o, pm_o, wb_en_o;
  logic [15:0] addr_o;
  logic [1:0]  wb_sel_o;
  logic [7:0]  wb_lo_o, wb_hi_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk_i = ~clk_i;

  adrgen_top u0 (.*);

  // expected: {vld, illegal, pm, wb_en, wb_sel[1:0], addr[15:0], wb[15:0]}
  function automatic logic [37:0] model(input logic rq, input logic [1:0] s,
      input logic [2:0] m, input logic [5:0] q, input logic [15:0] k,
      input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    logic [15:0] p, a, w;
    logic bad, pm, we;
    if (!rq) return '0;
    p = (s == 2'd0) ? x : (s == 2'd1) ? y : z;
    a = p; w = 16'd0; pm = 0; we = 0;
    bad = (s == 2'd3);
    case (m)
      3'd1: begin w = p + 16'd1; we = 1; end
      3'd2: begin a = p - 16'd1; w = a; we = 1; end
      3'd3: begin a = p + {10'd0, q}; bad = (s == 2'd3) || (s == 2'd0); end
      3'd4: begin a = k; bad = 0; end
      3'd5: begin pm = 1; bad = (s != 2'd2); end
      3'd6: begin pm = 1; w = p + 16'd1; we = 1; bad = (s != 2'd2); end
      3'd7: bad = 1;
      default: ;
    endcase
    if (bad) return {1'b0, 1'b1, 36'd0};
    return {1'b1, 1'b0, pm, we, we ? s : 2'd0, a, w};
  endfunction

  task automatic compare(input logic [37:0] exp, input string req);
    logic [37:0] act;
    act = {vld_o, illegal_o, pm_o, wb_en_o, wb_sel_o, addr_o, wb_hi_o, wb_lo_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic rq, input logic [1:0] s, input logic [2:0] m,
      input logic [5:0] q, input logic [15:0] k, input logic [15:0] x,
      input logic [15:0] y, input logic [15:0] z, input string req);
    req_i = rq; sel_i = s; mode_i = m; disp_i = q; direct_i = k;
    ptr_x_i = x; ptr_y_i = y; ptr_z_i = z;
    @(negedge clk_i);
    compare(model(rq, s, m, q, k, x, y, z), req);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    compare('0, "R12 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare('0, "R12 after release");
    apply(1, 0, 0, 0, 16'h0, 16'h1234, 16'h5678, 16'h9abc, "R2 plain X");
    apply(1, 1, 0, 0, 16'h0, 16'h1234, 16'h5678, 16'h9abc, "R2 plain Y");
    apply(1, 0, 1, 0, 16'h0, 16'h00ff, 16'h0, 16'h0, "R3 postinc X carry byte");
    apply(1, 1, 2, 0, 16'h0, 16'h0, 16'h0100, 16'h0, "R4 predec Y borrow byte");
    apply(1, 2, 3, 6'd63, 16'h0, 16'h0, 16'h0, 16'h1000, "R5 disp Z q=63");
    apply(1, 1, 3, 6'd0, 16'h0, 16'h0, 16'h2222, 16'h0, "R5 disp Y q=0");
    apply(1, 0, 3, 6'd5, 16'h0, 16'h3333, 16'h0, 16'h0, "R6 disp on X");
    apply(1, 3, 4, 0, 16'hbeef, 16'h1, 16'h2, 16'h3, "R7 direct sel=3");
    apply(1, 0, 4, 0, 16'h0042, 16'h1, 16'h2, 16'h3, "R7 direct sel=X");
    apply(1, 2, 5, 0, 16'h0, 16'h1, 16'h2, 16'h4444, "R8 pm Z");
    apply(1, 2, 6, 0, 16'h0, 16'h1, 16'h2, 16'h4444, "R8 pm Z postinc");
    apply(1, 1, 6, 0, 16'h0, 16'h1, 16'h2, 16'h3, "R9 pm on Y");
    apply(1, 3, 1, 0, 16'h0, 16'h1, 16'h2, 16'h3, "R9 sel=3 postinc");
    apply(1, 2, 7, 0, 16'h0, 16'h1, 16'h2, 16'h3, "R9 reserved mode");
    apply(1, 2, 6, 0, 16'h0, 16'h0, 16'h0, 16'hffff, "R10 pm Z wrap");
    apply(1, 0, 1, 0, 16'h0, 16'hffff, 16'h0, 16'h0, "R10 postinc wrap");
    apply(1, 2, 2, 0, 16'h0, 16'h0, 16'h0, 16'h0000, "R10 predec wrap");
    apply(1, 1, 3, 6'd2, 16'h0, 16'h0, 16'hfffe, 16'h0, "R10 disp wrap");
    apply(0, 1, 1, 0, 16'h0, 16'h5, 16'h5, 16'h5, "R1 idle");
    apply(1, 2, 1, 0, 16'h0, 16'h0, 16'h0, 16'h7777, "R11 wb_sel Z");
    for (int i = 0; i < 400; i++) begin
      logic [15:0] rx, ry, rz;
      rx = $urandom; ry = $urandom; rz = $urandom;
      if (i % 16 == 0) rz = 16'hffff;
      if (i % 16 == 1) ry = 16'h0000;
      apply(($urandom % 8) != 0, 2'($urandom), 3'($urandom), 6'($urandom),
            16'($urandom), rx, ry, rz, "R1 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule